// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers sixteen active-low interrupt request lines into one interrupt output for a processor. Even-numbered lines come from package pins and pass through a two-flop synchronizer. Odd-numbered lines come from on-chip sources and are always level sensitive. Each even line can instead be set to latch falling edges. A latched edge stays pending until software clears it by writing a one.

Software uses a word-addressed register port with four 32-bit registers. Word 0 is the enable word, word 1 the pending word, word 2 the sense-select word and word 3 the vector word. In the enable, pending and sense words, source n occupies bit 31−n. The vector word reports the most urgent enabled pending source, so an interrupt handler reads one register and knows which source to serve.

Top module: `prio_irq_ctrl`

## Requirements
- R1: In the enable (address 0), pending (address 1) and sense (address 2) words, source n is bit 31−n, so source 0 is bit 31; bits 15..0 read as zero.
- R2: A write to address 0 replaces the whole enable word, and reads return it. A source whose enable bit is 0 contributes neither to the vector nor to `cpu_irq_o`.
- R3: Writing to address 1 clears each edge-latched pending bit where the data bit is 1. Bits written as 0 are unchanged. A level-mode source keeps reporting its line.
- R4: An even source whose sense bit is 1 sets its pending bit on a falling edge of its pin. The bit appears 3 clock edges after the pin falls and holds after the pin returns high.
- R5: In level mode a pending bit reads 1 while the line is low. An even line shows this 2 edges after the pin changes (synchronizer), and an odd line shows it in the same cycle.
- R6: Sense bits of odd sources are not stored and read as 0. Odd sources stay level sensitive even when their sense bit is written as 1.
- R7: Address 3 reads the 6-bit source code in bits 31..26, with bits 25..0 zero.
- R8: When several enabled sources are pending, the vector shows the lowest-numbered one.
- R9: When no enabled source is pending, the vector code is 15.
- R10: `cpu_irq_o` is 1 exactly one clock edge after the AND of pending and enable is nonzero.
- R11: Reset clears the enable word, the sense word, the edge latches and `cpu_irq_o`. After reset the vector reads code 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word select: 0 enable, 1 pending, 2 sense, 3 vector |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_n_i | input | 16 | Active-low request lines, index = source number |
| cpu_irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Each result has its own latency. An odd level line shows in the pending word in the same cycle. An even level line shows after two edges, and an even edge line after three edges. The vector follows the pending word combinationally, and `cpu_irq_o` lags the vector by one more edge. The bench drives pins and the bus one time unit after a rising edge. It reads the combinational read port one time unit after setting the address, after the number of edges given above. The timing tests sample the cycle before each result is due and again the cycle it is due. The sweeps wait long enough for every path to settle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC     = 16;
    localparam int WORD_W   = 32;
    localparam int CODE_W   = 6;
    localparam int CODE_LSB = WORD_W - CODE_W;
    localparam int SPURIOUS = 15;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_PEND   = 2'd1,
        REG_SENSE  = 2'd2,
        REG_VECTOR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic lvl_act;
        logic fall;
    } line_ev_t;

    // source n lives at word bit (WORD_W-1-n)
    function automatic logic [WORD_W-1:0] src_to_word(input logic [NSRC-1:0] v);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < NSRC; i++) begin
            w[WORD_W-1-i] = v[i];
        end
        return w;
    endfunction

    function automatic logic [NSRC-1:0] word_to_src(input logic [WORD_W-1:0] w);
        logic [NSRC-1:0] v;
        for (int i = 0; i < NSRC; i++) begin
            v[i] = w[WORD_W-1-i];
        end
        return v;
    endfunction

endpackage

// File: rtl/irqc_line.sv
module irqc_line
    import irqc_pkg::*;
#(
    parameter bit EXTERNAL    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_n,
    output line_ev_t ev
);

    generate
        if (EXTERNAL) begin : g_ext
            logic [SYNC_STAGES-1:0] sync_q;
            logic                   prev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q <= '1;
                    prev_q <= 1'b1;
                end else begin
                    sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
                    prev_q <= sync_q[SYNC_STAGES-1];
                end
            end

            always_comb begin
                ev.lvl_act = ~sync_q[SYNC_STAGES-1];
                ev.fall    = prev_q & ~sync_q[SYNC_STAGES-1];
            end
        end else begin : g_int
            always_comb begin
                ev.lvl_act = ~pin_n;
                ev.fall    = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]   active,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        code = CODE_W'(SPURIOUS);
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                code = CODE_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   irq_n_i,
    output logic              cpu_irq_o
);

    reg_sel_e          sel;
    logic [NSRC-1:0]   enable_q;
    logic [NSRC-1:0]   sense_eff;
    logic [NSRC-1:0]   lat_q;
    logic [NSRC-1:0]   clr_v;
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   active;
    logic [CODE_W-1:0] vec_code;
    logic [NSRC-1:0]   wr_bits;
    logic              irq_q;
    line_ev_t          ev [NSRC];

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_bits = word_to_src(bus_wdata);
    assign clr_v   = (bus_wr && sel == REG_PEND) ? wr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (bus_wr && sel == REG_ENABLE) begin
            enable_q <= wr_bits;
        end
    end

    generate
        for (genvar n = 0; n < NSRC; n++) begin : g_src
            localparam bit IS_EXT = (n % 2) == 0;

            irqc_line #(
                .EXTERNAL    (IS_EXT),
                .SYNC_STAGES (SYNC_STAGES)
            ) line_i (
                .clk   (clk),
                .rst   (rst),
                .pin_n (irq_n_i[n]),
                .ev    (ev[n])
            );

            if (IS_EXT) begin : g_prog
                logic sense_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        sense_q <= 1'b0;
                    end else if (bus_wr && sel == REG_SENSE) begin
                        sense_q <= wr_bits[n];
                    end
                end
                assign sense_eff[n] = sense_q;
            end else begin : g_fixed
                assign sense_eff[n] = 1'b0;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    lat_q[n] <= 1'b0;
                end else if (sense_eff[n]) begin
                    lat_q[n] <= (lat_q[n] & ~clr_v[n]) | ev[n].fall;
                end else begin
                    lat_q[n] <= 1'b0;
                end
            end

            assign pend[n] = sense_eff[n] ? lat_q[n] : ev[n].lvl_act;
        end
    endgenerate

    assign active = pend & enable_q;

    irqc_prio prio_i (
        .active (active),
        .code   (vec_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |active;
        end
    end

    assign cpu_irq_o = irq_q;

    always_comb begin
        unique case (sel)
            REG_ENABLE: bus_rdata = src_to_word(enable_q);
            REG_PEND:   bus_rdata = src_to_word(pend);
            REG_SENSE:  bus_rdata = src_to_word(sense_eff);
            REG_VECTOR: bus_rdata = {vec_code, {CODE_LSB{1'b0}}};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              cpu_irq_o,
    input logic [NSRC-1:0]   active,
    input logic [NSRC-1:0]   lat_q,
    input logic [NSRC-1:0]   sense_eff,
    input logic [NSRC-1:0]   clr_v,
    input logic [CODE_W-1:0] vec_code
);

    a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cpu_irq_o == $past(|active));

    a_r9_spurious_code: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |-> (vec_code == CODE_W'(SPURIOUS)));

    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (active != '0) |-> (active[vec_code[3:0]] &&
            ((active & ((NSRC'(1) << vec_code[3:0]) - NSRC'(1))) == '0)));

    a_r6_odd_sense_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd2) |-> ((bus_rdata & 32'h5555_FFFF) == '0));

    a_r7_vector_low_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata[CODE_LSB-1:0] == '0));

    a_r4_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (($past(lat_q & sense_eff & ~clr_v) & sense_eff & ~lat_q) == '0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cpu_irq_o (cpu_irq_o),
    .active    (active),
    .lat_q     (lat_q),
    .sense_eff (sense_eff),
    .clr_v     (clr_v),
    .vec_code  (vec_code)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_n_i = '1;
    logic        cpu_irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n_i   (irq_n_i),
        .cpu_irq_o (cpu_irq_o)
    );

    task automatic tick(input int k = 1);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] bit_of(input int n);
        return 32'h8000_0000 >> n;
    endfunction

    function automatic logic [31:0] vec_of(input int n);
        return 32'(n) << 26;
    endfunction

    initial begin
        logic [31:0] d;
        tick(3);
        rst = 1'b0;
        tick();

        // R11 reset state
        rd_reg(2'd0, d); check("R11 enable", d, 32'h0);
        rd_reg(2'd2, d); check("R11 sense", d, 32'h0);
        rd_reg(2'd1, d); check("R11 pending", d, 32'h0);
        rd_reg(2'd3, d); check("R11 vector", d, vec_of(15));
        check("R11 irq", {31'b0, cpu_irq_o}, 32'h0);

        // R2 / R1 enable readback
        wr_reg(2'd0, 32'h1234_ABCD);
        rd_reg(2'd0, d); check("R2 R1 enable readback", d, 32'h1234_0000);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, d); check("R2 enable all", d, 32'hFFFF_0000);

        // R6 odd sense bits not stored
        wr_reg(2'd2, 32'hFFFF_FFFF);
        rd_reg(2'd2, d); check("R6 sense readback", d, 32'hAAAA_0000);
        wr_reg(2'd2, 32'h0);

        // R5 / R10 timing on an even level line
        irq_n_i[6] = 1'b0;
        tick();
        rd_reg(2'd1, d); check("R5 even level one edge", d, 32'h0);
        tick();
        rd_reg(2'd1, d); check("R5 even level two edges", d, bit_of(6));
        check("R10 irq not yet", {31'b0, cpu_irq_o}, 32'h0);
        tick();
        check("R10 irq due", {31'b0, cpu_irq_o}, 32'h1);
        irq_n_i[6] = 1'b1;
        tick(4);

        // R5 / R10 timing on an odd line
        irq_n_i[7] = 1'b0;
        rd_reg(2'd1, d); check("R5 odd level same cycle", d, bit_of(7));
        check("R10 odd irq not yet", {31'b0, cpu_irq_o}, 32'h0);
        tick();
        check("R10 odd irq due", {31'b0, cpu_irq_o}, 32'h1);
        irq_n_i[7] = 1'b1;
        tick(4);

        // R1 R5 R7 single-source level sweep
        for (int n = 0; n < 16; n++) begin
            irq_n_i[n] = 1'b0;
            tick(3);
            rd_reg(2'd1, d); check("R1 R5 pending sweep", d, bit_of(n));
            rd_reg(2'd3, d); check("R7 vector sweep", d, vec_of(n));
            check("R10 irq sweep", {31'b0, cpu_irq_o}, 32'h1);
            irq_n_i[n] = 1'b1;
            tick(3);
            rd_reg(2'd1, d); check("R5 released", d, 32'h0);
            check("R10 irq released", {31'b0, cpu_irq_o}, 32'h0);
        end

        // R8 priority over every pair
        for (int a = 0; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                irq_n_i[a] = 1'b0;
                irq_n_i[b] = 1'b0;
                tick(3);
                rd_reg(2'd3, d); check("R8 pair priority", d, vec_of(a));
                irq_n_i = '1;
                tick(3);
            end
        end
        rd_reg(2'd3, d); check("R9 idle vector", d, vec_of(15));

        // R2 disabled source ignored
        wr_reg(2'd0, bit_of(5));
        irq_n_i[3] = 1'b0;
        tick(3);
        rd_reg(2'd1, d); check("R2 pending still shown", d, bit_of(3));
        rd_reg(2'd3, d); check("R2 R9 disabled vector", d, vec_of(15));
        check("R2 disabled irq", {31'b0, cpu_irq_o}, 32'h0);
        wr_reg(2'd0, bit_of(5) | bit_of(3));
        rd_reg(2'd3, d); check("R2 enabled vector", d, vec_of(3));
        tick();
        check("R2 enabled irq", {31'b0, cpu_irq_o}, 32'h1);
        irq_n_i = '1;
        wr_reg(2'd0, 32'hFFFF_FFFF);
        tick(3);

        // R3 write-one on a level source has no effect
        irq_n_i[2] = 1'b0;
        tick(3);
        wr_reg(2'd1, 32'hFFFF_FFFF);
        rd_reg(2'd1, d); check("R3 level not cleared", d, bit_of(2));
        irq_n_i = '1;
        tick(3);

        // R6 odd line stays level with sense written
        wr_reg(2'd2, 32'hFFFF_FFFF);
        irq_n_i[3] = 1'b0;
        tick(3);
        rd_reg(2'd1, d); check("R6 odd level asserted", d, bit_of(3));
        irq_n_i[3] = 1'b1;
        tick();
        rd_reg(2'd1, d); check("R6 odd level released", d, 32'h0);

        // R4 / R3 edge mode on every even line
        for (int n = 0; n < 16; n += 2) begin
            irq_n_i[n] = 1'b0;
            tick(2);
            rd_reg(2'd1, d); check("R4 edge not yet", d, 32'h0);
            tick();
            rd_reg(2'd1, d); check("R4 edge latched", d, bit_of(n));
            irq_n_i[n] = 1'b1;
            tick(4);
            rd_reg(2'd1, d); check("R4 edge held", d, bit_of(n));
            rd_reg(2'd3, d); check("R4 edge vector", d, vec_of(n));
            check("R10 edge irq", {31'b0, cpu_irq_o}, 32'h1);
            wr_reg(2'd1, ~bit_of(n));
            rd_reg(2'd1, d); check("R3 zero write keeps", d, bit_of(n));
            wr_reg(2'd1, bit_of(n));
            rd_reg(2'd1, d); check("R3 one write clears", d, 32'h0);
            tick();
            check("R10 irq after clear", {31'b0, cpu_irq_o}, 32'h0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule